// File: doc/BRIEF.md
# Cache Control Register File

This block is a small register file through which software sets up the caches of a processor core. It keeps one 32-bit control word that holds a two-bit state code for each cache, a freeze-on-interrupt enable for each cache, and a set of ordinary stored bits. Two read-only words report the fixed geometry of the instruction cache and of the data cache. The block only models the register side. It has no cache arrays, and it does no real flush, snoop or burst work.

Software reaches the registers through a synchronous request port. That port carries a valid strobe, a write flag, a 4-bit byte offset, 32-bit write data and an access-size code. Read data is registered. It appears in the cycle after the request and stays there until the next read.

A separate one-cycle pulse tells the block that the core has taken an interrupt. On that pulse, any cache whose freeze enable is set and whose state is enabled drops to frozen. This happens without any software action.

Top module: `cachectl_regs`

## Requirements
- R1: After synchronous reset the control word is all zeros, so both cache states read as disabled (00), and the read data output is zero.
- R2: A 32-bit write to offset 0x0 stores the write data into the control word, with bits 14, 15, 16, 21 and 22 forced to zero. These bits always read back as zero. Every other bit, bit 23 included, reads back as written.
- R3: A 32-bit read at offset 0x4 returns 0x10220000 and a 32-bit read at offset 0x8 returns 0x18220000. Writes to either offset change neither these values nor the control word.
- R4: The instruction cache state sits in bits [1:0] and its freeze enable in bit 4. The data cache state sits in bits [3:2] and its freeze enable in bit 5. State codes are 00 disabled, 01 frozen and 11 enabled. When the interrupt pulse is high and a cache's freeze enable is set, a state of 11 becomes 01.
- R5: The interrupt pulse leaves a cache state unchanged when that cache's freeze enable is clear or when its state is anything other than 11. All other control bits are never touched by the pulse.
- R6: When a control-word write and the interrupt pulse fall in the same cycle, the freeze rule is applied to the newly written (masked) value.
- R7: The access-size code 2'b10 means 32 bits. For any other code (00, 01, 11), a write is ignored and a read returns zero.
- R8: Only address bits [3:0] are decoded. A read at offset 0xC or at a non-word-aligned offset returns zero, and a write there is discarded.
- R9: Read data is registered. It shows the addressed value in the cycle after a read request, reflecting the control word as it was before that cycle's update. It holds its value while no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access size code: 00 byte, 01 half, 10 word, 11 reserved |
| irq_taken | input | 1 | One-cycle pulse: an interrupt has been taken |
| rd_data | output | 32 | Registered read data |

## Verification
The bench targets the cases where a plausible design goes wrong. These are an interrupt landing in the same cycle as a control write, where a design that freezes the old value would leave an enabled cache running. They also include a state of 10 or 00 at interrupt time, which a careless comparison might turn into frozen. Wrong-size and unaligned accesses are exercised because a design that decodes only the offset would write the control word or leak register contents. Reads of the write-only command bits and of bit 23 are checked, which expose a mask that is off by one position. Random traffic then compares every read against a bench model, including the hold of read data across idle cycles.

// File: rtl/cachectl_pkg.sv
// Shared constants and types for the cache control register file.
// Assumes a 32-bit register width; all encodings live here.
package cachectl_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int NUM_CACHES = 2;

    // Two-bit cache state codes
    localparam logic [1:0] ST_OFF = 2'b00;
    localparam logic [1:0] ST_FRZ = 2'b01;
    localparam logic [1:0] ST_ON  = 2'b11;

    // Field positions in the control word
    localparam int STATE_LSB = 0;
    localparam int FRZ_LSB   = 4;

    // Access size code meaning a full word
    localparam logic [1:0] SZ_WORD = 2'b10;

    // Command bits that are never stored (14,15,16,21,22)
    localparam logic [DATA_W-1:0] WO_BITS  = 32'h0061_C000;

    // Fixed geometry words
    localparam logic [DATA_W-1:0] ICFG_VAL = 32'h1022_0000;
    localparam logic [DATA_W-1:0] DCFG_VAL = 32'h1822_0000;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ICFG = 2'd1,
        SEL_DCFG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/cachectl_decode.sv
// Address decoder: maps a byte offset onto a register select.
// Assumes word registers at offsets 0x0, 0x4, 0x8; anything else,
// including a misaligned offset, selects nothing.
module cachectl_decode
    import cachectl_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic [ADDR_W_P-1:0] addr,
    output reg_sel_e            sel
);

    localparam int WORD_IDX_W = ADDR_W_P - 2;

    // Purpose: pick the register selected by a word-aligned offset
    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            case (addr[ADDR_W_P-1:2])
                WORD_IDX_W'(0): sel = SEL_CTRL;
                WORD_IDX_W'(1): sel = SEL_ICFG;
                WORD_IDX_W'(2): sel = SEL_DCFG;
                default:        sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cachectl_freeze.sv
// Freeze-on-interrupt transform of the control word.
// One slice per cache: if the interrupt pulse is high and the cache's
// freeze enable is set, an enabled state becomes frozen. Other bits pass.
module cachectl_freeze
    import cachectl_pkg::*;
#(
    parameter int DATA_W_P     = DATA_W,
    parameter int NUM_CACHES_P = NUM_CACHES,
    parameter int STATE_LSB_P  = STATE_LSB,
    parameter int FRZ_LSB_P    = FRZ_LSB
) (
    input  logic                irq,
    input  logic [DATA_W_P-1:0] ctrl_in,
    output logic [DATA_W_P-1:0] ctrl_out
);

    logic [1:0] new_st [NUM_CACHES_P];

    for (genvar i = 0; i < NUM_CACHES_P; i++) begin : g_cache
        localparam int SL = STATE_LSB_P + 2 * i;
        localparam int FB = FRZ_LSB_P + i;

        // Purpose: next state for cache i under the freeze rule
        always_comb begin
            new_st[i] = ctrl_in[SL +: 2];
            if (irq && ctrl_in[FB] && (ctrl_in[SL +: 2] == ST_ON)) begin
                new_st[i] = ST_FRZ;
            end
        end
    end

    // Purpose: splice the per-cache states back into the word
    always_comb begin
        ctrl_out = ctrl_in;
        for (int i = 0; i < NUM_CACHES_P; i++) begin
            ctrl_out[STATE_LSB_P + 2 * i +: 2] = new_st[i];
        end
    end

endmodule

// File: rtl/cachectl_rdmux.sv
// Read data selection. Returns zero for a wrong access size or an
// unmapped select; assumes the caller registers the result.
module cachectl_rdmux
    import cachectl_pkg::*;
#(
    parameter int DATA_W_P = DATA_W
) (
    input  reg_sel_e            sel,
    input  logic                size_ok,
    input  logic [DATA_W_P-1:0] ctrl,
    output logic [DATA_W_P-1:0] rdata
);

    // Purpose: choose the word addressed by a read
    always_comb begin
        rdata = '0;
        if (size_ok) begin
            case (sel)
                SEL_CTRL: rdata = ctrl;
                SEL_ICFG: rdata = ICFG_VAL;
                SEL_DCFG: rdata = DCFG_VAL;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cachectl_regs.sv
// Top: cache control register file.
// Holds the control word, applies the write mask and the freeze rule
// (freeze acts on the value being written when both coincide), and
// registers read data. Assumes one access per cycle and a one-cycle
// interrupt pulse. Reset is synchronous, active low.
module cachectl_regs
    import cachectl_pkg::*;
#(
    parameter int DATA_W_P     = DATA_W,
    parameter int ADDR_W_P     = ADDR_W,
    parameter int NUM_CACHES_P = NUM_CACHES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W_P-1:0] req_addr,
    input  logic [DATA_W_P-1:0] req_wdata,
    input  logic [1:0]          req_size,
    input  logic                irq_taken,
    output logic [DATA_W_P-1:0] rd_data
);

    reg_sel_e            sel;
    logic                size_ok;
    logic                wr_hit;
    logic                rd_req;
    logic [DATA_W_P-1:0] ctrl_q;
    logic [DATA_W_P-1:0] ctrl_wr;
    logic [DATA_W_P-1:0] ctrl_d;
    logic [DATA_W_P-1:0] rd_mux;
    logic [DATA_W_P-1:0] rd_q;

    cachectl_decode #(.ADDR_W_P(ADDR_W_P)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    // Purpose: qualify the request
    always_comb begin
        size_ok = (req_size == SZ_WORD);
        wr_hit  = req_valid && req_write && size_ok && (sel == SEL_CTRL);
        rd_req  = req_valid && !req_write;
    end

    // Purpose: masked write value or current word
    always_comb begin
        ctrl_wr = wr_hit ? (req_wdata & ~WO_BITS) : ctrl_q;
    end

    cachectl_freeze #(
        .DATA_W_P     (DATA_W_P),
        .NUM_CACHES_P (NUM_CACHES_P),
        .STATE_LSB_P  (STATE_LSB),
        .FRZ_LSB_P    (FRZ_LSB)
    ) u_freeze (
        .irq      (irq_taken),
        .ctrl_in  (ctrl_wr),
        .ctrl_out (ctrl_d)
    );

    // Purpose: control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    cachectl_rdmux #(.DATA_W_P(DATA_W_P)) u_rdmux (
        .sel     (sel),
        .size_ok (size_ok),
        .ctrl    (ctrl_q),
        .rdata   (rd_mux)
    );

    // Purpose: registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_req) rd_q <= rd_mux;
    end

    assign rd_data = rd_q;

    // ---------------- assertions ----------------

    // R2: command bits never stored
    p_wo_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((ctrl_q & WO_BITS) == '0));

    // R3/R7/R8: without a control write or interrupt the word holds
    p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !irq_taken) |=> $stable(ctrl_q));

    // R4: enabled instruction cache with freeze enable becomes frozen
    p_freeze_icache_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !wr_hit && ctrl_q[FRZ_LSB] && ctrl_q[STATE_LSB +: 2] == ST_ON)
        |=> (ctrl_q[STATE_LSB +: 2] == ST_FRZ));

    // R4: same for the data cache
    p_freeze_dcache_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !wr_hit && ctrl_q[FRZ_LSB+1] && ctrl_q[STATE_LSB+2 +: 2] == ST_ON)
        |=> (ctrl_q[STATE_LSB+2 +: 2] == ST_FRZ));

    // R5: no freeze enables -> interrupt changes nothing
    p_no_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !wr_hit && !ctrl_q[FRZ_LSB] && !ctrl_q[FRZ_LSB+1])
        |=> $stable(ctrl_q));

    // R7: wrong-size read returns zero
    p_size_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != SZ_WORD) |=> (rd_data == '0));

    // R3: instruction cache geometry readback
    p_icfg_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && size_ok && req_addr == ADDR_W_P'(4)) |=> (rd_data == ICFG_VAL));

    // R9: read data holds while no read
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

endmodule

// File: tb/cachectl_regs_tb.sv
// Bench for cachectl_regs: directed corner cases then seeded random
// traffic, all checked against a bench-side model of the control word.
module cachectl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  req_size;
    logic        irq_taken;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_ctrl;
    logic [31:0] m_rd;

    always #5 clk = ~clk;

    cachectl_regs dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_size  (req_size),
        .irq_taken (irq_taken),
        .rd_data   (rd_data)
    );

    // R2 mask: bits 14,15,16,21,22 cleared
    function automatic logic [31:0] f_mask(input logic [31:0] d);
        return d & ~32'h0061_C000;
    endfunction

    // R4/R5 freeze rule
    function automatic logic [31:0] f_freeze(input logic [31:0] c);
        logic [31:0] r = c;
        for (int i = 0; i < 2; i++)
            if (c[4+i] && c[2*i +: 2] == 2'b11) r[2*i +: 2] = 2'b01;
        return r;
    endfunction

    // R3/R7/R8 read value
    function automatic logic [31:0] f_read(input logic [3:0] a, input logic [1:0] sz,
                                           input logic [31:0] c);
        if (sz != 2'b10 || a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return c;
            2'd1: return 32'h1022_0000;
            2'd2: return 32'h1822_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One cycle of traffic; rd_data is checked against the model afterwards
    task automatic step(input bit v, input bit w, input logic [3:0] a,
                        input logic [31:0] d, input logic [1:0] sz, input bit irq,
                        input string tag);
        logic [31:0] nc;
        req_valid = v; req_write = w; req_addr = a;
        req_wdata = d; req_size = sz; irq_taken = irq;
        if (v && !w) m_rd = f_read(a, sz, m_ctrl);
        nc = (v && w && sz == 2'b10 && a == 4'h0) ? f_mask(d) : m_ctrl;
        if (irq) nc = f_freeze(nc);
        m_ctrl = nc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; irq_taken = 1'b0;
        check(tag, rd_data, m_rd);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit irq, input string tag);
        step(1'b1, 1'b1, a, d, 2'b10, irq, tag);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        step(1'b1, 1'b0, a, 32'h0, 2'b10, 1'b0, tag);
        check({tag, " direct"}, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = 0;
        req_wdata = 0; req_size = 0; irq_taken = 0;
        m_ctrl = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data after reset", rd_data, 32'h0);
        rd(4'h0, 32'h0, "R1 ctrl after reset");

        wr(4'h0, 32'hFFFF_FFFF, 1'b0, "R2 write all ones");
        rd(4'h0, 32'hFF9E_3FFF, "R2 command bits read zero");
        wr(4'h0, 32'h0080_0000, 1'b0, "R2 bit23");
        rd(4'h0, 32'h0080_0000, "R2 bit23 stored");

        rd(4'h4, 32'h1022_0000, "R3 icfg");
        rd(4'h8, 32'h1822_0000, "R3 dcfg");
        wr(4'h4, 32'hDEAD_BEEF, 1'b0, "R3 write icfg");
        wr(4'h8, 32'h1234_5678, 1'b0, "R3 write dcfg");
        rd(4'h4, 32'h1022_0000, "R3 icfg after write");
        rd(4'h0, 32'h0080_0000, "R3 ctrl untouched");

        wr(4'h0, 32'h0000_003F, 1'b0, "R4 setup");
        step(1'b0, 1'b0, 4'h0, 32'h0, 2'b10, 1'b1, "R4 irq");
        rd(4'h0, 32'h0000_0035, "R4 both frozen");
        wr(4'h0, 32'h0000_001F, 1'b0, "R4 setup icache only");
        step(1'b0, 1'b0, 4'h0, 32'h0, 2'b10, 1'b1, "R4 irq");
        rd(4'h0, 32'h0000_001D, "R4 icache frozen dcache kept");

        wr(4'h0, 32'h0000_000F, 1'b0, "R5 setup no freeze enables");
        step(1'b0, 1'b0, 4'h0, 32'h0, 2'b10, 1'b1, "R5 irq");
        rd(4'h0, 32'h0000_000F, "R5 unchanged");
        wr(4'h0, 32'h0000_0032, 1'b0, "R5 setup state 10/00");
        step(1'b0, 1'b0, 4'h0, 32'h0, 2'b10, 1'b1, "R5 irq");
        rd(4'h0, 32'h0000_0032, "R5 non-enabled states kept");

        wr(4'h0, 32'h0000_003F, 1'b1, "R6 write with irq");
        rd(4'h0, 32'h0000_0035, "R6 freeze on new value");

        step(1'b1, 1'b1, 4'h0, 32'h0000_000C, 2'b00, 1'b0, "R7 byte write");
        step(1'b1, 1'b1, 4'h0, 32'h0000_000C, 2'b01, 1'b0, "R7 half write");
        rd(4'h0, 32'h0000_0035, "R7 ctrl unchanged");
        step(1'b1, 1'b0, 4'h4, 32'h0, 2'b11, 1'b0, "R7 reserved-size read");
        check("R7 reserved-size read zero", rd_data, 32'h0);

        rd(4'hC, 32'h0, "R8 unmapped read");
        wr(4'hC, 32'hFFFF_FFFF, 1'b0, "R8 unmapped write");
        rd(4'h1, 32'h0, "R8 unaligned read");
        wr(4'h1, 32'h0000_0000, 1'b0, "R8 unaligned write");
        rd(4'h0, 32'h0000_0035, "R8 ctrl unchanged");

        rd(4'h8, 32'h1822_0000, "R9 read");
        step(1'b0, 1'b0, 4'h0, 32'h0, 2'b10, 1'b0, "R9 idle");
        check("R9 hold", rd_data, 32'h1822_0000);
        wr(4'h0, 32'h0000_001B, 1'b0, "R9 setup");
        step(1'b1, 1'b0, 4'h0, 32'h0, 2'b10, 1'b1, "R9 read with irq");
        check("R9 read sees old word", rd_data, 32'h0000_001B);
        rd(4'h0, 32'h0000_0019, "R9 freeze landed");

        for (int n = 0; n < 600; n++) begin
            logic [3:0]  a  = ($urandom % 4 == 0) ? 4'($urandom) : {2'($urandom % 4), 2'b00};
            logic [1:0]  sz = ($urandom % 5 == 0) ? 2'($urandom) : 2'b10;
            logic [31:0] d  = ($urandom % 2 == 0) ? ($urandom & 32'h0000_003F) : $urandom;
            bit          v  = ($urandom % 6 != 0);
            bit          w  = $urandom % 2;
            bit          ir = ($urandom % 4 == 0);
            step(v, w, a, d, sz, ir, "R9 random traffic");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule